// File: doc/BRIEF.md
# Queue-Port Host Messaging Unit

This block is the device-side messaging unit between a host and a local processing engine. The host uses a 32-bit register interface. The unit holds three queues. The first is a free list of request offsets in device memory, filled with a computed series of offsets at reset. The second is a post queue of work the host has handed over. The third is a completion queue of finished work. Two port addresses carry all queued traffic. Reading the first port takes a free slot and writing it posts work. Reading the second port collects a completion and writing it hands a slot back to the free list.

A posted word with its top bit set refers to a request that lives in host memory. Its low 31 bits are the bus address shifted right by five, so such requests must sit on 32-byte boundaries. The unit decodes this tag for the device and presents either the rebuilt bus address or the plain offset. Non-queued commands travel through two inbound message words. The device acknowledges a command by writing the same value into the matching outbound message word. A doorbell word collects single-bit events from the host. Each direction has a status word and a mask word. The device receives one interrupt line and the host receives another.

Top module: `qport_msg_unit`

## Requirements
- R1: Host reads return inbound message 0 and 1 at 0x10 and 0x14, outbound message 0 and 1 at 0x18 and 0x1C, and the doorbell at 0x20. Host writes to 0x18 and 0x1C have no effect. Unmapped addresses read as zero.
- R2: At reset the free list holds FREE_BASE + i*FREE_STEP for i = 0..QDEPTH-1. Each host read of 0x40 returns and removes the oldest entry.
- R3: Each host write to 0x40 appends the value to the post queue. The device sees the oldest entry with dev_post_valid high and removes it with dev_post_pop, in write order.
- R4: A post-queue entry with bit 31 set is flagged as host memory, and its bus address is bits 30:0 shifted left by 5. With bit 31 clear, the entry is a device offset and the address output is the zero-extended value.
- R5: A dev_cmpl_push appends dev_cmpl_data to the completion queue. Outbound status bit 2 reads 1 whenever that queue is not empty.
- R6: A host read of 0x44 returns and removes the oldest completion. A host write to 0x44 appends the value to the free list.
- R7: A host read of 0x40 or 0x44 while the queue behind it is empty returns 0xFFFFFFFF and leaves the queue unchanged.
- R8: Status words are at 0x24 (inbound) and 0x30 (outbound), and mask words are at 0x28 and 0x34. A mask resets to 0. Writing 1 to a sticky status bit clears it. dev_irq and host_irq are the OR of their status bits whose mask bit is 0.
- R9: A push into a full queue of any of the three is dropped and sets sticky outbound status bit 3.
- R10: A host write of 0x10 or 0x14 sets inbound status bit 0 or 1, and dev_in_ack clears those bits. A dev_omsg_we[k] write stores the word and sets outbound status bit k.
- R11: A host write to 0x20 ORs the value into the doorbell and dev_db_clr clears the selected bits. Inbound status bit 2 reads 1 while the doorbell is nonzero, and bit 3 reads 1 while the post queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | ADDR_W | Host register byte address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe; a pop takes effect at the clock edge |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid in the cycle of h_rd |
| host_irq | output | 1 | Interrupt to the host |
| dev_post_valid | output | 1 | Post queue holds an entry |
| dev_post_data | output | 32 | Oldest posted word |
| dev_post_is_host | output | 1 | Oldest posted word refers to host memory |
| dev_post_addr | output | BUS_AW | Decoded address or offset of the oldest posted word |
| dev_post_pop | input | 1 | Device removes the oldest posted word |
| dev_cmpl_push | input | 1 | Device appends a completion |
| dev_cmpl_data | input | 32 | Completion word |
| dev_imsg0 | output | 32 | Inbound message word 0 |
| dev_imsg1 | output | 32 | Inbound message word 1 |
| dev_omsg_we | input | 2 | Device write enables for outbound message words 1:0 |
| dev_omsg_data | input | 32 | Device outbound message data |
| dev_in_ack | input | 2 | Device clears inbound status bits 1:0 |
| dev_doorbell | output | 32 | Current doorbell word |
| dev_db_clr | input | 32 | Device clears doorbell bits |
| dev_irq | output | 1 | Interrupt to the device |

## Verification
The hardest conditions to reach from the ports are the dropped pushes and the empty reads, because each needs a queue brought exactly to full or to empty first. The bench drains the prefilled free list with host reads until the empty code appears. It fills the post queue and the completion queue one entry past their depth, then drains them and compares order, tag decode and the sticky overflow flag against arithmetic expectations. Mask and clear writes are then swept so that each interrupt line is seen both raised and suppressed.

// File: rtl/qpmu_pkg.sv
package qpmu_pkg;
   localparam int OFS_IMSG0  = 'h10;
   localparam int OFS_IMSG1  = 'h14;
   localparam int OFS_OMSG0  = 'h18;
   localparam int OFS_OMSG1  = 'h1C;
   localparam int OFS_DBELL  = 'h20;
   localparam int OFS_ISTAT  = 'h24;
   localparam int OFS_IMASK  = 'h28;
   localparam int OFS_OSTAT  = 'h30;
   localparam int OFS_OMASK  = 'h34;
   localparam int OFS_INPORT = 'h40;
   localparam int OFS_OUTPORT= 'h44;

   localparam int STAT_W     = 4;
   // status bit positions
   localparam int SB_MSG0    = 0;
   localparam int SB_MSG1    = 1;
   localparam int SB_LEVEL   = 2;  // doorbell (in) / completions pending (out)
   localparam int SB_QUEUE   = 3;  // post queue pending (in) / overflow (out)

   localparam logic [31:0] EMPTY_CODE = 32'hFFFF_FFFF;
   localparam int          ALIGN_SH   = 5;
endpackage

// File: rtl/qpmu_fifo.sv
module qpmu_fifo #(
   parameter int DW        = 32,
   parameter int DEPTH     = 8,
   parameter bit INIT_FILL = 1'b0,
   parameter int INIT_BASE = 0,
   parameter int INIT_STEP = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full,
   output logic          drop
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_FULL  = CW'(DEPTH);
   localparam logic [CW-1:0] CNT_RESET = INIT_FILL ? CW'(DEPTH) : '0;

   if (DEPTH < 1) begin : g_bad_depth
      $error("qpmu_fifo: DEPTH must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   assign empty   = (count == '0);
   assign full    = (count == CNT_FULL);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign drop    = push && !do_push;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= CNT_RESET;
      end else begin
         if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
         if (do_push) wr_ptr <= step_ptr(wr_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   if (INIT_FILL) begin : g_prefill
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
               mem[i] <= DW'(INIT_BASE + i * INIT_STEP);
         end else if (do_push) begin
            mem[wr_ptr] <= wdata;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (do_push) mem[wr_ptr] <= wdata;
      end
   end

   // a push into a full queue without a pop leaves the fill level alone
   assert_drop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == $past(count)));
   // a real removal lowers the fill level by one
   assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> (count == $past(count) - CW'(1)));
   // popping an empty queue moves no pointer
   assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (rd_ptr == $past(rd_ptr) && count == '0));
endmodule

// File: rtl/qpmu_irq_bank.sv
module qpmu_irq_bank #(
   parameter int           W      = 4,
   parameter logic [W-1:0] STICKY = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   input  logic [W-1:0] live,
   input  logic         w1c_we,
   input  logic [W-1:0] w1c_data,
   input  logic         mask_we,
   input  logic [W-1:0] mask_data,
   output logic [W-1:0] status,
   output logic [W-1:0] mask,
   output logic         irq
);
   logic [W-1:0] sticky_q, mask_q, w1c_bits;

   assign w1c_bits = w1c_we ? w1c_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sticky_q <= '0;
         mask_q   <= '0;
      end else begin
         sticky_q <= ((sticky_q & ~w1c_bits & ~clr) | set) & STICKY;
         if (mask_we) mask_q <= mask_data;
      end
   end

   assign status = sticky_q | (live & ~STICKY);
   assign mask   = mask_q;
   assign irq    = |(status & ~mask_q);

   // write-one-to-clear removes a sticky bit unless it is set again
   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      w1c_we |=> ((sticky_q & $past(w1c_data & ~set)) == '0));
   // a set event is visible in the following cycle
   assert_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((sticky_q & $past(set)) == $past(set & STICKY)));
endmodule

// File: rtl/qpmu_tag_decode.sv
module qpmu_tag_decode #(
   parameter int BUS_AW   = 36,
   parameter int ALIGN_SH = 5
) (
   input  logic [31:0]       word,
   output logic              is_host,
   output logic [BUS_AW-1:0] addr
);
   if (BUS_AW < 31 + ALIGN_SH) begin : g_bad_aw
      $error("qpmu_tag_decode: BUS_AW too narrow for shifted host address");
   end

   assign is_host = word[31];

   if (ALIGN_SH == 0) begin : g_noshift
      assign addr = word[31] ? BUS_AW'(word[30:0]) : BUS_AW'(word);
   end else begin : g_shift
      assign addr = word[31] ? BUS_AW'({word[30:0], {ALIGN_SH{1'b0}}})
                             : BUS_AW'(word);
   end
endmodule

// File: rtl/qport_msg_unit.sv
module qport_msg_unit
   import qpmu_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int QDEPTH    = 8,
   parameter int FREE_BASE = 'h1000,
   parameter int FREE_STEP = 'h100,
   parameter int BUS_AW    = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [31:0]       h_wdata,
   output logic [31:0]       h_rdata,
   output logic              host_irq,
   output logic              dev_post_valid,
   output logic [31:0]       dev_post_data,
   output logic              dev_post_is_host,
   output logic [BUS_AW-1:0] dev_post_addr,
   input  logic              dev_post_pop,
   input  logic              dev_cmpl_push,
   input  logic [31:0]       dev_cmpl_data,
   output logic [31:0]       dev_imsg0,
   output logic [31:0]       dev_imsg1,
   input  logic [1:0]        dev_omsg_we,
   input  logic [31:0]       dev_omsg_data,
   input  logic [1:0]        dev_in_ack,
   output logic [31:0]       dev_doorbell,
   input  logic [31:0]       dev_db_clr,
   output logic              dev_irq
);
   if (QDEPTH < 2) begin : g_bad_qdepth
      $error("qport_msg_unit: QDEPTH must be at least 2");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("qport_msg_unit: ADDR_W must reach offset 0x44");
   end
   if (FREE_STEP <= 0) begin : g_bad_step
      $error("qport_msg_unit: FREE_STEP must be positive");
   end

   // ---------------- address decode ----------------
   logic sel_imsg0, sel_imsg1, sel_omsg0, sel_omsg1, sel_dbell;
   logic sel_istat, sel_imask, sel_ostat, sel_omask, sel_inport, sel_outport;

   assign sel_imsg0   = (h_addr == ADDR_W'(OFS_IMSG0));
   assign sel_imsg1   = (h_addr == ADDR_W'(OFS_IMSG1));
   assign sel_omsg0   = (h_addr == ADDR_W'(OFS_OMSG0));
   assign sel_omsg1   = (h_addr == ADDR_W'(OFS_OMSG1));
   assign sel_dbell   = (h_addr == ADDR_W'(OFS_DBELL));
   assign sel_istat   = (h_addr == ADDR_W'(OFS_ISTAT));
   assign sel_imask   = (h_addr == ADDR_W'(OFS_IMASK));
   assign sel_ostat   = (h_addr == ADDR_W'(OFS_OSTAT));
   assign sel_omask   = (h_addr == ADDR_W'(OFS_OMASK));
   assign sel_inport  = (h_addr == ADDR_W'(OFS_INPORT));
   assign sel_outport = (h_addr == ADDR_W'(OFS_OUTPORT));

   logic wr_imsg0, wr_imsg1, wr_dbell, wr_inport, wr_outport;
   logic rd_inport, rd_outport;

   assign wr_imsg0   = h_wr && sel_imsg0;
   assign wr_imsg1   = h_wr && sel_imsg1;
   assign wr_dbell   = h_wr && sel_dbell;
   assign wr_inport  = h_wr && sel_inport;
   assign wr_outport = h_wr && sel_outport;
   assign rd_inport  = h_rd && sel_inport;
   assign rd_outport = h_rd && sel_outport;

   // ---------------- queues ----------------
   logic [31:0] free_rdata, post_rdata, cmpl_rdata;
   logic        free_empty, post_empty, cmpl_empty;
   logic        free_full,  post_full,  cmpl_full;
   logic        free_drop,  post_drop,  cmpl_drop;
   logic        any_drop;

   qpmu_fifo #(
      .DW(32), .DEPTH(QDEPTH), .INIT_FILL(1'b1),
      .INIT_BASE(FREE_BASE), .INIT_STEP(FREE_STEP)
   ) u_free (
      .clk(clk), .rst_n(rst_n),
      .push(wr_outport), .wdata(h_wdata),
      .pop(rd_inport), .rdata(free_rdata),
      .empty(free_empty), .full(free_full), .drop(free_drop)
   );

   qpmu_fifo #(
      .DW(32), .DEPTH(QDEPTH), .INIT_FILL(1'b0),
      .INIT_BASE(0), .INIT_STEP(0)
   ) u_post (
      .clk(clk), .rst_n(rst_n),
      .push(wr_inport), .wdata(h_wdata),
      .pop(dev_post_pop), .rdata(post_rdata),
      .empty(post_empty), .full(post_full), .drop(post_drop)
   );

   qpmu_fifo #(
      .DW(32), .DEPTH(QDEPTH), .INIT_FILL(1'b0),
      .INIT_BASE(0), .INIT_STEP(0)
   ) u_cmpl (
      .clk(clk), .rst_n(rst_n),
      .push(dev_cmpl_push), .wdata(dev_cmpl_data),
      .pop(rd_outport), .rdata(cmpl_rdata),
      .empty(cmpl_empty), .full(cmpl_full), .drop(cmpl_drop)
   );

   assign any_drop = free_drop | post_drop | cmpl_drop;

   // ---------------- device view of posted work ----------------
   assign dev_post_valid = !post_empty;
   assign dev_post_data  = post_rdata;

   qpmu_tag_decode #(.BUS_AW(BUS_AW), .ALIGN_SH(ALIGN_SH)) u_tag (
      .word(post_rdata), .is_host(dev_post_is_host), .addr(dev_post_addr)
   );

   // ---------------- message words and doorbell ----------------
   logic [31:0] imsg0_q, imsg1_q, omsg0_q, omsg1_q, dbell_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imsg0_q <= '0;
         imsg1_q <= '0;
         omsg0_q <= '0;
         omsg1_q <= '0;
         dbell_q <= '0;
      end else begin
         if (wr_imsg0)       imsg0_q <= h_wdata;
         if (wr_imsg1)       imsg1_q <= h_wdata;
         if (dev_omsg_we[0]) omsg0_q <= dev_omsg_data;
         if (dev_omsg_we[1]) omsg1_q <= dev_omsg_data;
         dbell_q <= (dbell_q & ~dev_db_clr) | (wr_dbell ? h_wdata : '0);
      end
   end

   assign dev_imsg0    = imsg0_q;
   assign dev_imsg1    = imsg1_q;
   assign dev_doorbell = dbell_q;

   // ---------------- status and mask ----------------
   logic [STAT_W-1:0] in_set, in_clr, in_live, in_status, in_mask;
   logic [STAT_W-1:0] out_set, out_live, out_status, out_mask;

   always_comb begin
      in_set            = '0;
      in_set[SB_MSG0]   = wr_imsg0;
      in_set[SB_MSG1]   = wr_imsg1;
      in_clr            = '0;
      in_clr[SB_MSG0]   = dev_in_ack[0];
      in_clr[SB_MSG1]   = dev_in_ack[1];
      in_live           = '0;
      in_live[SB_LEVEL] = |dbell_q;
      in_live[SB_QUEUE] = !post_empty;

      out_set            = '0;
      out_set[SB_MSG0]   = dev_omsg_we[0];
      out_set[SB_MSG1]   = dev_omsg_we[1];
      out_set[SB_QUEUE]  = any_drop;
      out_live           = '0;
      out_live[SB_LEVEL] = !cmpl_empty;
   end

   localparam logic [STAT_W-1:0] IN_STICKY  = STAT_W'((1 << SB_MSG0) | (1 << SB_MSG1));
   localparam logic [STAT_W-1:0] OUT_STICKY = STAT_W'((1 << SB_MSG0) | (1 << SB_MSG1)
                                                      | (1 << SB_QUEUE));

   qpmu_irq_bank #(.W(STAT_W), .STICKY(IN_STICKY)) u_in_irq (
      .clk(clk), .rst_n(rst_n),
      .set(in_set), .clr(in_clr), .live(in_live),
      .w1c_we(h_wr && sel_istat), .w1c_data(h_wdata[STAT_W-1:0]),
      .mask_we(h_wr && sel_imask), .mask_data(h_wdata[STAT_W-1:0]),
      .status(in_status), .mask(in_mask), .irq(dev_irq)
   );

   qpmu_irq_bank #(.W(STAT_W), .STICKY(OUT_STICKY)) u_out_irq (
      .clk(clk), .rst_n(rst_n),
      .set(out_set), .clr('0), .live(out_live),
      .w1c_we(h_wr && sel_ostat), .w1c_data(h_wdata[STAT_W-1:0]),
      .mask_we(h_wr && sel_omask), .mask_data(h_wdata[STAT_W-1:0]),
      .status(out_status), .mask(out_mask), .irq(host_irq)
   );

   // ---------------- host read mux ----------------
   always_comb begin
      h_rdata = '0;
      unique case (1'b1)
         sel_imsg0:   h_rdata = imsg0_q;
         sel_imsg1:   h_rdata = imsg1_q;
         sel_omsg0:   h_rdata = omsg0_q;
         sel_omsg1:   h_rdata = omsg1_q;
         sel_dbell:   h_rdata = dbell_q;
         sel_istat:   h_rdata = 32'(in_status);
         sel_imask:   h_rdata = 32'(in_mask);
         sel_ostat:   h_rdata = 32'(out_status);
         sel_omask:   h_rdata = 32'(out_mask);
         sel_inport:  h_rdata = free_empty ? EMPTY_CODE : free_rdata;
         sel_outport: h_rdata = cmpl_empty ? EMPTY_CODE : cmpl_rdata;
         default:     h_rdata = '0;
      endcase
   end

   // an empty completion port reads as the empty code
   assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd && sel_outport && cmpl_empty) |-> (h_rdata == EMPTY_CODE));
   // every dropped push leaves the overflow flag standing
   assert_drop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_drop |=> out_status[SB_QUEUE]);
   // a completion push always leaves completions pending
   assert_cmpl_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_cmpl_push |=> out_status[SB_LEVEL]);
   // a host-memory tag always yields an aligned bus address
   assert_tag_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_post_valid && dev_post_is_host) |-> (dev_post_addr[ALIGN_SH-1:0] == '0));
endmodule

// File: tb/sim_qport_msg_unit.sv
module sim_qport_msg_unit;
   localparam int QD    = 4;
   localparam int BASE  = 'h2000;
   localparam int STEP  = 'h80;
   localparam int BAW   = 36;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      h_addr = '0;
   logic            h_wr = 1'b0, h_rd = 1'b0;
   logic [31:0]     h_wdata = '0;
   logic [31:0]     h_rdata;
   logic            host_irq, dev_irq;
   logic            dev_post_valid, dev_post_is_host;
   logic [31:0]     dev_post_data;
   logic [BAW-1:0]  dev_post_addr;
   logic            dev_post_pop = 1'b0;
   logic            dev_cmpl_push = 1'b0;
   logic [31:0]     dev_cmpl_data = '0;
   logic [31:0]     dev_imsg0, dev_imsg1, dev_doorbell;
   logic [1:0]      dev_omsg_we = '0;
   logic [31:0]     dev_omsg_data = '0;
   logic [1:0]      dev_in_ack = '0;
   logic [31:0]     dev_db_clr = '0;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   qport_msg_unit #(
      .ADDR_W(8), .QDEPTH(QD), .FREE_BASE(BASE), .FREE_STEP(STEP), .BUS_AW(BAW)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
      .h_rdata(h_rdata), .host_irq(host_irq),
      .dev_post_valid(dev_post_valid), .dev_post_data(dev_post_data),
      .dev_post_is_host(dev_post_is_host), .dev_post_addr(dev_post_addr),
      .dev_post_pop(dev_post_pop),
      .dev_cmpl_push(dev_cmpl_push), .dev_cmpl_data(dev_cmpl_data),
      .dev_imsg0(dev_imsg0), .dev_imsg1(dev_imsg1),
      .dev_omsg_we(dev_omsg_we), .dev_omsg_data(dev_omsg_data),
      .dev_in_ack(dev_in_ack),
      .dev_doorbell(dev_doorbell), .dev_db_clr(dev_db_clr),
      .dev_irq(dev_irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      h_addr = a; h_wdata = d; h_wr = 1'b1;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      h_addr = a; h_rd = 1'b1;
      #1 d = h_rdata;
      @(negedge clk);
      h_rd = 1'b0;
   endtask

   task automatic cmpl_push(input logic [31:0] d);
      @(negedge clk);
      dev_cmpl_data = d; dev_cmpl_push = 1'b1;
      @(negedge clk);
      dev_cmpl_push = 1'b0;
   endtask

   function automatic logic [31:0] post_val(input int i);
      if (i % 2 == 0) return 32'h8000_0000 | 32'(i * 'h1234 + 'h77);
      else            return 32'(BASE + i * STEP);
   endfunction

   function automatic logic [BAW-1:0] post_addr(input logic [31:0] v);
      if (v[31]) return BAW'(v & 32'h7FFF_FFFF) << 5;
      else       return BAW'(v);
   endfunction

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R8)
      chk("R8 reset host_irq", 64'(host_irq), 64'd0);
      chk("R8 reset dev_irq", 64'(dev_irq), 64'd0);
      hread(8'h30, rd); chk("R8 reset out status", 64'(rd), 64'd0);
      hread(8'h24, rd); chk("R8 reset in status", 64'(rd), 64'd0);
      chk("R3 reset post valid", 64'(dev_post_valid), 64'd0);

      // messages (R1, R10)
      hwrite(8'h10, 32'hA5A5_0001);
      hread(8'h10, rd); chk("R1 imsg0 readback", 64'(rd), 64'hA5A5_0001);
      chk("R10 dev_imsg0", 64'(dev_imsg0), 64'hA5A5_0001);
      chk("R10 dev_irq on msg", 64'(dev_irq), 64'd1);
      hwrite(8'h14, 32'h0BAD_F00D);
      hread(8'h14, rd); chk("R1 imsg1 readback", 64'(rd), 64'h0BAD_F00D);
      hread(8'h24, rd); chk("R10 in status two msgs", 64'(rd), 64'h3);
      hwrite(8'h24, 32'h1);
      hread(8'h24, rd); chk("R8 in w1c bit0", 64'(rd), 64'h2);
      @(negedge clk); dev_in_ack = 2'b10; @(negedge clk); dev_in_ack = 2'b00;
      hread(8'h24, rd); chk("R10 device ack", 64'(rd), 64'h0);
      chk("R8 dev_irq cleared", 64'(dev_irq), 64'd0);
      hread(8'h08, rd); chk("R1 unmapped reads zero", 64'(rd), 64'd0);

      @(negedge clk); dev_omsg_we = 2'b01; dev_omsg_data = 32'hA5A5_0001;
      @(negedge clk); dev_omsg_we = 2'b00;
      hread(8'h18, rd); chk("R10 omsg0 echo", 64'(rd), 64'hA5A5_0001);
      hread(8'h30, rd); chk("R10 out status msg0", 64'(rd), 64'h1);
      chk("R8 host_irq on omsg", 64'(host_irq), 64'd1);
      hwrite(8'h30, 32'h1);
      hread(8'h30, rd); chk("R8 out w1c", 64'(rd), 64'h0);
      chk("R8 host_irq cleared", 64'(host_irq), 64'd0);
      @(negedge clk); dev_omsg_we = 2'b10; dev_omsg_data = 32'h1357_9BDF;
      @(negedge clk); dev_omsg_we = 2'b00;
      hread(8'h1C, rd); chk("R1 omsg1 readback", 64'(rd), 64'h1357_9BDF);
      hwrite(8'h18, 32'hDEAD_BEEF);
      hread(8'h18, rd); chk("R1 omsg0 host write ignored", 64'(rd), 64'hA5A5_0001);
      hwrite(8'h30, 32'h2);

      // free list (R2, R7, R6)
      for (int i = 0; i < QD; i++) begin
         hread(8'h40, rd);
         chk("R2 free list order", 64'(rd), 64'(BASE + i * STEP));
      end
      hread(8'h40, rd); chk("R7 empty free read", 64'(rd), 64'hFFFF_FFFF);
      hread(8'h40, rd); chk("R7 empty free read repeat", 64'(rd), 64'hFFFF_FFFF);
      hread(8'h30, rd); chk("R7 empty read no overflow", 64'(rd), 64'h0);
      hwrite(8'h44, 32'h0000_3300);
      hwrite(8'h44, 32'h0000_3380);
      hread(8'h40, rd); chk("R6 returned slot 1", 64'(rd), 64'h3300);
      hread(8'h40, rd); chk("R6 returned slot 2", 64'(rd), 64'h3380);
      hread(8'h40, rd); chk("R7 free empty again", 64'(rd), 64'hFFFF_FFFF);

      // post queue fill and overflow (R3, R4, R9, R11)
      for (int i = 0; i < QD; i++) hwrite(8'h40, post_val(i));
      hread(8'h24, rd); chk("R11 post pending bit", 64'(rd), 64'h8);
      chk("R11 dev_irq post pending", 64'(dev_irq), 64'd1);
      hwrite(8'h40, 32'h1111_2222);
      hread(8'h30, rd); chk("R9 post overflow flag", 64'(rd), 64'h8);
      chk("R9 host_irq on overflow", 64'(host_irq), 64'd1);
      for (int i = 0; i < QD; i++) begin
         @(negedge clk);
         chk("R3 post valid", 64'(dev_post_valid), 64'd1);
         chk("R3 post order", 64'(dev_post_data), 64'(post_val(i)));
         chk("R4 host tag", 64'(dev_post_is_host), 64'(post_val(i) >> 31));
         chk("R4 decoded address", 64'(dev_post_addr), 64'(post_addr(post_val(i))));
         dev_post_pop = 1'b1;
         @(negedge clk);
         dev_post_pop = 1'b0;
      end
      @(negedge clk);
      chk("R9 dropped post absent", 64'(dev_post_valid), 64'd0);
      hwrite(8'h30, 32'h8);
      hread(8'h30, rd); chk("R9 overflow cleared", 64'(rd), 64'h0);
      hread(8'h24, rd); chk("R11 post pending gone", 64'(rd), 64'h0);

      // completions (R5, R6, R8, R7, R9)
      for (int i = 0; i < 3; i++) cmpl_push(32'hC000_0000 + 32'(i * 'h11));
      chk("R5 host_irq on completion", 64'(host_irq), 64'd1);
      hread(8'h30, rd); chk("R5 completion level bit", 64'(rd), 64'h4);
      hwrite(8'h34, 32'h4);
      chk("R8 masked irq", 64'(host_irq), 64'd0);
      hread(8'h30, rd); chk("R8 mask keeps status", 64'(rd), 64'h4);
      hread(8'h34, rd); chk("R8 mask readback", 64'(rd), 64'h4);
      hwrite(8'h34, 32'h0);
      chk("R8 unmasked irq", 64'(host_irq), 64'd1);
      for (int i = 0; i < 3; i++) begin
         hread(8'h44, rd);
         chk("R6 completion order", 64'(rd), 64'(32'hC000_0000 + 32'(i * 'h11)));
      end
      hread(8'h30, rd); chk("R5 level clears when drained", 64'(rd), 64'h0);
      chk("R5 host_irq low drained", 64'(host_irq), 64'd0);
      hread(8'h44, rd); chk("R7 empty completion read", 64'(rd), 64'hFFFF_FFFF);
      for (int i = 0; i <= QD; i++) cmpl_push(32'h00D0_0000 + 32'(i));
      hread(8'h30, rd); chk("R9 completion overflow", 64'(rd), 64'hC);
      for (int i = 0; i < QD; i++) begin
         hread(8'h44, rd);
         chk("R9 kept completions", 64'(rd), 64'(32'h00D0_0000 + 32'(i)));
      end
      hread(8'h44, rd); chk("R9 overflow entry dropped", 64'(rd), 64'hFFFF_FFFF);
      hwrite(8'h30, 32'hF);

      // doorbell (R11)
      hwrite(8'h20, 32'h5);
      hwrite(8'h20, 32'h2);
      hread(8'h20, rd); chk("R11 doorbell OR", 64'(rd), 64'h7);
      chk("R11 dev_doorbell", 64'(dev_doorbell), 64'h7);
      hread(8'h24, rd); chk("R11 doorbell status", 64'(rd), 64'h4);
      @(negedge clk); dev_db_clr = 32'h1; @(negedge clk); dev_db_clr = '0;
      hread(8'h20, rd); chk("R11 doorbell partial clear", 64'(rd), 64'h6);
      hwrite(8'h28, 32'h4);
      chk("R8 in mask suppresses", 64'(dev_irq), 64'd0);
      hwrite(8'h28, 32'h0);
      @(negedge clk); dev_db_clr = 32'h6; @(negedge clk); dev_db_clr = '0;
      hread(8'h24, rd); chk("R11 doorbell status clear", 64'(rd), 64'h0);
      chk("R11 dev_irq idle", 64'(dev_irq), 64'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule